// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of a 12-bit multiplying DAC whose input latch is transparent and is controlled by two active-low strobes: a chip-select and a write. A producer hands over one sample at a time with a valid/ready handshake. The sequencer then puts the word on the parallel bus, lowers chip-select, lowers write, and raises both strobes together. It keeps the word on the bus for a hold interval and then reports completion with a single-cycle pulse.

The latch follows the bus for as long as both strobes are low. For that reason the word is always on the bus before either strobe falls, and it does not move until both have risen. Each phase length is a whole number of clock cycles. It is derived at elaboration from the clock period and from the minimum times in nanoseconds. The block holds two timing sets: one for a low supply voltage and one for a high supply voltage. An input picks between them for each sample. A second per-sample input turns two's-complement samples into offset binary by inverting the top bit.

Top module: `dac_wr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dac_cs_n` and `dac_wr_n` are 1, `dac_data` is 0, `s_ready` is 1 and `done` is 0.
- R2: `s_ready` is 1 only while the sequencer is idle. A sample is taken only on a clock edge where `s_valid` and `s_ready` are both 1. A `s_valid` raised during a write sequence starts nothing.
- R3: The first cycle after acceptance shows the new word on `dac_data` with both strobes high. Exactly 1 such cycle passes before `dac_cs_n` falls. `dac_wr_n` is never low while `dac_cs_n` is high.
- R4: `dac_cs_n` is low alone, ahead of `dac_wr_n` falling, for ceil(tCS / Tclk) cycles. tCS is 380 ns when `hv_sel`=0 and 200 ns when `hv_sel`=1. At the default 5 ns clock that gives 76 and 40 cycles.
- R5: Both strobes are low together for the larger of ceil(tWR / Tclk) and ceil(tDS / Tclk). tWR/tDS are 400/210 ns when `hv_sel`=0 and 240/120 ns when `hv_sel`=1. At the default clock that gives 80 and 48 cycles.
- R6: While either strobe is low, `dac_data` does not change and equals the formatted accepted word.
- R7: `dac_cs_n` and `dac_wr_n` rise on the same clock edge.
- R8: After the strobes rise, the word stays on `dac_data` for 1 release cycle plus ceil(10 ns / Tclk) hold cycles. That is 3 cycles at the default clock. The bus then keeps that word until the next acceptance.
- R9: With `bipolar`=1, bit 11 of the sample is inverted on its way to `dac_data` (0x7FF gives 0xFFF, 0x800 gives 0x000). With `bipolar`=0, the word passes through unchanged.
- R10: `hv_sel`, `bipolar` and `s_sample` are sampled only at acceptance. Changes to them later in the same sequence have no effect on the bus or the phase lengths.
- R11: `done` is 1 for exactly one cycle, the first idle cycle after the hold phase, which is also the cycle in which `s_ready` returns to 1.
- R12: Each phase length is rounded up to whole cycles and is never shorter than 1 cycle, even when its minimum time is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | A sample is offered |
| s_ready | output | 1 | Sequencer is idle and takes the offered sample |
| s_sample | input | DATA_W | Sample word, bit DATA_W-1 is the MSB |
| hv_sel | input | 1 | Timing set: 0 low supply, 1 high supply |
| bipolar | input | 1 | 1 inverts the MSB (two's complement to offset binary) |
| dac_data | output | DATA_W | Parallel DAC data bus |
| dac_cs_n | output | 1 | DAC chip-select, active low |
| dac_wr_n | output | 1 | DAC write strobe, active low |
| done | output | 1 | One-cycle pulse when the hold phase ends |

## Verification
The assertions assume a clean reset, and they assume inputs change only away from the active clock edge. Within those limits they hold for any pattern of `s_valid`, including a `s_valid` held high continuously. The stimulus changes inputs only at falling edges and sweeps all four combinations of supply and code mode. In some sequences it deliberately raises `s_valid` and toggles the mode inputs and sample while a write is in progress. This checks that these inputs are ignored outside the idle state, and the bench still waits for `done` before starting the next sample.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_DRIVE = 3'd1,
      ST_CS    = 3'd2,
      ST_WR    = 3'd3,
      ST_REL   = 3'd4,
      ST_HOLD  = 3'd5
   } seq_state_t;

   // Minimum time in ns to clock cycles, rounded up, never below one.
   function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                             input int unsigned per_ps);
      int unsigned c;
      c = (t_ns * 1000 + per_ps - 1) / per_ps;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned bits_for(input int unsigned v);
      int unsigned b;
      b = 1;
      while ((1 << b) <= v) b++;
      return b;
   endfunction

endpackage

// File: rtl/dac_code_fmt.sv
module dac_code_fmt #(
   parameter int unsigned DATA_W     = 12,
   parameter bit          BIPOLAR_EN = 1'b1
) (
   input  logic [DATA_W-1:0] raw_i,
   input  logic              bipolar_i,
   output logic [DATA_W-1:0] code_o
);

   generate
      if (BIPOLAR_EN) begin : g_flip
         always_comb begin
            code_o = raw_i;
            if (bipolar_i) code_o[DATA_W-1] = ~raw_i[DATA_W-1];
         end
      end else begin : g_pass
         logic unused_bip;
         assign unused_bip = bipolar_i;
         assign code_o     = raw_i;
      end
   endgenerate

endmodule

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (load_i)          cnt_q <= load_val_i;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/dac_timing_sel.sv
module dac_timing_sel
   import dac_seq_pkg::*;
#(
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter int unsigned CNT_W         = 8,
   parameter bit          HV_SET_EN     = 1'b1,
   parameter int unsigned LV_CS_NS      = 380,
   parameter int unsigned LV_WR_NS      = 400,
   parameter int unsigned LV_DS_NS      = 210,
   parameter int unsigned LV_DH_NS      = 10,
   parameter int unsigned HV_CS_NS      = 200,
   parameter int unsigned HV_WR_NS      = 240,
   parameter int unsigned HV_DS_NS      = 120,
   parameter int unsigned HV_DH_NS      = 10
) (
   input  logic             hv_i,
   output logic [CNT_W-1:0] cs_ld_o,
   output logic [CNT_W-1:0] wr_ld_o,
   output logic [CNT_W-1:0] dh_ld_o
);

   localparam int unsigned LV_CS = ns_to_cyc(LV_CS_NS, CLK_PERIOD_PS);
   localparam int unsigned LV_WR = max2(ns_to_cyc(LV_WR_NS, CLK_PERIOD_PS),
                                        ns_to_cyc(LV_DS_NS, CLK_PERIOD_PS));
   localparam int unsigned LV_DH = ns_to_cyc(LV_DH_NS, CLK_PERIOD_PS);
   localparam int unsigned HV_CS = ns_to_cyc(HV_CS_NS, CLK_PERIOD_PS);
   localparam int unsigned HV_WR = max2(ns_to_cyc(HV_WR_NS, CLK_PERIOD_PS),
                                        ns_to_cyc(HV_DS_NS, CLK_PERIOD_PS));
   localparam int unsigned HV_DH = ns_to_cyc(HV_DH_NS, CLK_PERIOD_PS);

   localparam logic [CNT_W-1:0] LV_CS_LD = CNT_W'(LV_CS - 1);
   localparam logic [CNT_W-1:0] LV_WR_LD = CNT_W'(LV_WR - 1);
   localparam logic [CNT_W-1:0] LV_DH_LD = CNT_W'(LV_DH - 1);
   localparam logic [CNT_W-1:0] HV_CS_LD = CNT_W'(HV_CS - 1);
   localparam logic [CNT_W-1:0] HV_WR_LD = CNT_W'(HV_WR - 1);
   localparam logic [CNT_W-1:0] HV_DH_LD = CNT_W'(HV_DH - 1);

   if (bits_for(max2(max2(LV_CS, LV_WR), max2(HV_CS, HV_WR))) > CNT_W) begin : g_bad_cnt
      $error("dac_timing_sel: CNT_W too narrow for phase lengths");
   end

   generate
      if (HV_SET_EN) begin : g_two_sets
         always_comb begin
            if (hv_i) begin
               cs_ld_o = HV_CS_LD;
               wr_ld_o = HV_WR_LD;
               dh_ld_o = HV_DH_LD;
            end else begin
               cs_ld_o = LV_CS_LD;
               wr_ld_o = LV_WR_LD;
               dh_ld_o = LV_DH_LD;
            end
         end
      end else begin : g_one_set
         logic unused_hv;
         assign unused_hv = hv_i;
         assign cs_ld_o   = LV_CS_LD;
         assign wr_ld_o   = LV_WR_LD;
         assign dh_ld_o   = LV_DH_LD;
      end
   endgenerate

endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
   import dac_seq_pkg::*;
#(
   parameter int unsigned DATA_W        = 12,
   parameter int unsigned CLK_PERIOD_PS = 5000,
   parameter bit          BIPOLAR_EN    = 1'b1,
   parameter bit          HV_SET_EN     = 1'b1,
   parameter int unsigned DRIVE_CYC     = 1,
   parameter int unsigned LV_CS_NS      = 380,
   parameter int unsigned LV_WR_NS      = 400,
   parameter int unsigned LV_DS_NS      = 210,
   parameter int unsigned LV_DH_NS      = 10,
   parameter int unsigned HV_CS_NS      = 200,
   parameter int unsigned HV_WR_NS      = 240,
   parameter int unsigned HV_DS_NS      = 120,
   parameter int unsigned HV_DH_NS      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_sample,
   input  logic              hv_sel,
   input  logic              bipolar,
   output logic [DATA_W-1:0] dac_data,
   output logic              dac_cs_n,
   output logic              dac_wr_n,
   output logic              done
);

   localparam int unsigned MAX_NS  = max2(max2(max2(LV_CS_NS, LV_WR_NS), max2(LV_DS_NS, LV_DH_NS)),
                                          max2(max2(HV_CS_NS, HV_WR_NS), max2(HV_DS_NS, HV_DH_NS)));
   localparam int unsigned MAX_CYC = max2(ns_to_cyc(MAX_NS, CLK_PERIOD_PS), DRIVE_CYC);
   localparam int unsigned CNT_W   = bits_for(MAX_CYC);
   localparam logic [CNT_W-1:0] DRIVE_LD = CNT_W'((DRIVE_CYC == 0) ? 0 : DRIVE_CYC - 1);

   if (DATA_W < 2) begin : g_bad_w
      $error("dac_wr_seq: DATA_W must be at least 2");
   end
   if (CLK_PERIOD_PS == 0) begin : g_bad_clk
      $error("dac_wr_seq: CLK_PERIOD_PS must be non-zero");
   end

   seq_state_t        state_q, state_d;
   logic [DATA_W-1:0] data_q;
   logic [DATA_W-1:0] fmt_code;
   logic              hv_q;
   logic              cs_n_q, wr_n_q, done_q;
   logic              accept;
   logic              load;
   logic [CNT_W-1:0]  load_val;
   logic              expired;
   logic [CNT_W-1:0]  cs_ld, wr_ld, dh_ld;

   dac_code_fmt #(
      .DATA_W     (DATA_W),
      .BIPOLAR_EN (BIPOLAR_EN)
   ) u_fmt (
      .raw_i     (s_sample),
      .bipolar_i (bipolar),
      .code_o    (fmt_code)
   );

   dac_timing_sel #(
      .CLK_PERIOD_PS (CLK_PERIOD_PS),
      .CNT_W         (CNT_W),
      .HV_SET_EN     (HV_SET_EN),
      .LV_CS_NS      (LV_CS_NS),
      .LV_WR_NS      (LV_WR_NS),
      .LV_DS_NS      (LV_DS_NS),
      .LV_DH_NS      (LV_DH_NS),
      .HV_CS_NS      (HV_CS_NS),
      .HV_WR_NS      (HV_WR_NS),
      .HV_DS_NS      (HV_DS_NS),
      .HV_DH_NS      (HV_DH_NS)
   ) u_tsel (
      .hv_i    (hv_q),
      .cs_ld_o (cs_ld),
      .wr_ld_o (wr_ld),
      .dh_ld_o (dh_ld)
   );

   dac_phase_timer #(
      .CNT_W (CNT_W)
   ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .expired_o  (expired)
   );

   assign s_ready = (state_q == ST_IDLE);
   assign accept  = s_valid && s_ready;

   always_comb begin
      state_d  = state_q;
      load     = 1'b0;
      load_val = '0;
      unique case (state_q)
         ST_IDLE: if (accept) begin
            state_d  = ST_DRIVE;
            load     = 1'b1;
            load_val = DRIVE_LD;
         end
         ST_DRIVE: if (expired) begin
            state_d  = ST_CS;
            load     = 1'b1;
            load_val = cs_ld;
         end
         ST_CS: if (expired) begin
            state_d  = ST_WR;
            load     = 1'b1;
            load_val = wr_ld;
         end
         ST_WR: if (expired) begin
            state_d  = ST_REL;
            load     = 1'b1;
            load_val = '0;
         end
         ST_REL: begin
            state_d  = ST_HOLD;
            load     = 1'b1;
            load_val = dh_ld;
         end
         ST_HOLD: if (expired) state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         data_q  <= '0;
         hv_q    <= 1'b0;
         cs_n_q  <= 1'b1;
         wr_n_q  <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cs_n_q  <= !((state_d == ST_CS) || (state_d == ST_WR));
         wr_n_q  <= !(state_d == ST_WR);
         done_q  <= (state_q == ST_HOLD) && (state_d == ST_IDLE);
         if (accept) begin
            data_q <= fmt_code;
            hv_q   <= hv_sel;
         end
      end
   end

   assign dac_data = data_q;
   assign dac_cs_n = cs_n_q;
   assign dac_wr_n = wr_n_q;
   assign done     = done_q;

endmodule

// File: rtl/dac_wr_seq_chk.sv
module dac_wr_seq_chk #(
   parameter int unsigned DATA_W     = 12,
   parameter bit          BIPOLAR_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_valid,
   input logic              s_ready,
   input logic [DATA_W-1:0] s_sample,
   input logic              hv_sel,
   input logic              bipolar,
   input logic [DATA_W-1:0] dac_data,
   input logic              dac_cs_n,
   input logic              dac_wr_n,
   input logic              done
);

   logic unused_hv;
   assign unused_hv = hv_sel;

   AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      !dac_wr_n |-> !dac_cs_n); // R3

   AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> (!s_ready && dac_cs_n && dac_wr_n)); // R3

   AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (dac_cs_n && dac_wr_n)); // R2

   AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!dac_cs_n || !dac_wr_n) |=> $stable(dac_data)); // R6

   AST_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dac_wr_n) |-> $rose(dac_cs_n)); // R7

   AST_IDLE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready && !s_valid) |=> $stable(dac_data)); // R8

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> s_ready); // R11

   generate
      if (BIPOLAR_EN) begin : g_bip_chk
         AST_MSB_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
            (s_valid && s_ready && bipolar) |=>
               (dac_data == {~$past(s_sample[DATA_W-1]), $past(s_sample[DATA_W-2:0])})); // R9
      end
   endgenerate

   AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready && !bipolar) |=> (dac_data == $past(s_sample))); // R9

endmodule

bind dac_wr_seq dac_wr_seq_chk #(
   .DATA_W     (DATA_W),
   .BIPOLAR_EN (BIPOLAR_EN)
) u_chk (.*);

// File: tb/sim_dac_wr_seq.sv
module sim_dac_wr_seq;

   localparam int DW        = 12;
   localparam int PERIOD_NS = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_valid = 1'b0;
   logic          s_ready;
   logic [DW-1:0] s_sample = '0;
   logic          hv_sel = 1'b0;
   logic          bipolar = 1'b0;
   logic [DW-1:0] dac_data;
   logic          dac_cs_n, dac_wr_n, done;

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   dac_wr_seq u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_valid  (s_valid),
      .s_ready  (s_ready),
      .s_sample (s_sample),
      .hv_sel   (hv_sel),
      .bipolar  (bipolar),
      .dac_data (dac_data),
      .dac_cs_n (dac_cs_n),
      .dac_wr_n (dac_wr_n),
      .done     (done)
   );

   function automatic int cyc(input int t_ns);
      int c;
      c = (t_ns + PERIOD_NS - 1) / PERIOD_NS;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // One complete write; when disturb is set, inputs are wiggled mid-sequence.
   task automatic do_txn(input logic [DW-1:0] w, input bit hv, input bit bip, input bit disturb);
      logic [DW-1:0] exp_d;
      int exp_cs, exp_wr, exp_post;
      int n;
      exp_d    = bip ? (w ^ 12'h800) : w;                       // R9
      exp_cs   = hv ? cyc(200) : cyc(380);                      // R4, R12
      exp_wr   = hv ? mx(cyc(240), cyc(120)) : mx(cyc(400), cyc(210)); // R5
      exp_post = 1 + cyc(10);                                   // R8

      @(negedge clk);
      chk(s_ready == 1'b1, "R2 ready in idle", s_ready, 1);
      s_valid = 1'b1; s_sample = w; hv_sel = hv; bipolar = bip;
      @(negedge clk);
      s_valid = 1'b0;
      if (disturb) begin                                        // R10, R2
         s_valid = 1'b1; s_sample = ~w; hv_sel = ~hv; bipolar = ~bip;
      end
      chk(s_ready == 1'b0, "R2 busy after accept", s_ready, 0);
      chk(dac_data == exp_d, "R9 formatted word on bus", dac_data, exp_d);

      n = 0;
      while (dac_cs_n && dac_wr_n && n < 1000) begin n++; @(negedge clk); end
      chk(n == 1, "R3 drive phase length", n, 1);
      chk(!dac_cs_n && dac_wr_n, "R3 cs falls before wr", {dac_cs_n, dac_wr_n}, 2'b01);

      n = 0;
      while (!dac_cs_n && dac_wr_n && n < 1000) begin n++; @(negedge clk); end
      chk(n == exp_cs, "R4 cs lead cycles", n, exp_cs);

      n = 0;
      while (!dac_cs_n && !dac_wr_n && n < 1000) begin
         chk(dac_data == exp_d, "R6 bus stable while strobed", dac_data, exp_d);
         n++; @(negedge clk);
      end
      chk(n == exp_wr, "R5 write pulse cycles", n, exp_wr);
      chk(dac_cs_n && dac_wr_n, "R7 strobes rise together", {dac_cs_n, dac_wr_n}, 2'b11);
      s_valid = 1'b0;

      n = 0;
      while (!done && n < 1000) begin
         chk(dac_data == exp_d, "R8 bus held after strobes", dac_data, exp_d);
         n++; @(negedge clk);
      end
      chk(n == exp_post, "R8 release plus hold cycles", n, exp_post);
      chk(s_ready == 1'b1, "R11 ready with done", s_ready, 1);
      @(negedge clk);
      chk(done == 1'b0, "R11 done single cycle", done, 0);
      chk(dac_data == exp_d, "R8 bus kept in idle", dac_data, exp_d);
   endtask

   initial begin
      #(200000 * PERIOD_NS);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(dac_cs_n == 1'b1, "R1 cs high in reset", dac_cs_n, 1);
      chk(dac_wr_n == 1'b1, "R1 wr high in reset", dac_wr_n, 1);
      chk(dac_data == '0,  "R1 bus zero in reset", dac_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(s_ready == 1'b1, "R1 ready after reset", s_ready, 1);
      chk(done == 1'b0,    "R1 done low after reset", done, 0);
      chk(dac_cs_n && dac_wr_n, "R1 strobes high after reset", {dac_cs_n, dac_wr_n}, 2'b11);

      for (int mode = 0; mode < 4; mode++) begin
         do_txn(12'h7FF, mode[0], mode[1], 1'b0);
         do_txn(12'h800, mode[0], mode[1], 1'b0);
         do_txn(12'hFFF, mode[0], mode[1], 1'b1);
         do_txn(12'h000, mode[0], mode[1], 1'b1);
         for (int k = 0; k < 64; k++) begin
            do_txn(12'((k * 65) & 12'hFFF), mode[0], mode[1], k[2]);
         end
      end
      finish_run();
   end

endmodule